// File: doc/BRIEF.md
# Serial Boot Clock and Bit-Rate Parameter Checker

During a serial boot session a host asks for a clock setting and a serial bit rate. This block checks that request. For the clock, it derives the operating frequency from the input frequency and a ratio. A mode flag selects whether the ratio multiplies or divides. The block then tests the result against an inclusive window `[op_min_i, op_max_i]` for the chosen clock mode.

For the bit rate, it computes the denominator that the prescaler and divisor produce: `(brdiv_i + 1) × baud_i × 2^(5 + 2·cks_i)`. This equals `(N+1)·B·64·2^(2n−1)`, with the half-step at n = 0 handled as a base of 32. It compares that denominator with the peripheral clock without dividing. The bit-rate flag is set when `25·|per_clk_i − den| ≥ den`, which means the rate error is 4 % or more.

One cycle of `start_i` launches the check. The block latches every parameter and runs two shift-add multipliers and one restoring divider in parallel. It then judges both conditions and pulses `done_o` for one cycle. The two flags stay unchanged until the next accepted start.

The controller has four states:
- **ST_IDLE**: waits. `start_i` is accepted only here (transition *launch*).
- **ST_CALC**: waits until both arithmetic paths have finished (transition *results ready*).
- **ST_JUDGE**: registers both flags (transition *judged*).
- **ST_REPORT**: drives `done_o` for one cycle and returns to ST_IDLE (transition *reported*).

Top module: `bootparam_checker`

## Requirements
- R1: With `div_sel_i` = 0 the operating frequency is `in_freq_i × ratio_i`. `freq_err_o` is 1 exactly when that value is below `op_min_i` or above `op_max_i`. Values equal to either bound pass.
- R2: With `div_sel_i` = 1 the operating frequency is `in_freq_i / ratio_i`, truncated toward zero. It goes through the same inclusive window test.
- R3: With `div_sel_i` = 1 and `ratio_i` = 0, `freq_err_o` is 1 whatever the window.
- R4: The bit-rate denominator is `(brdiv_i + 1) × baud_i` shifted left by 5, 7, 9 or 11 for `cks_i` = 0, 1, 2, 3.
- R5: `baud_err_o` is 1 when `25 × |per_clk_i − den| ≥ den`. An error of exactly 4 % is flagged, and anything strictly below passes. With `baud_i` = 0 the flag is 1.
- R6: After an accepted start, `done_o` is high for exactly one cycle. Both flags are valid in that cycle and stay unchanged until the next accepted start.
- R7: A `start_i` pulse while a check is in progress is ignored. The reported flags belong to the parameters present at the accepted start.
- R8: After reset, `done_o`, `freq_err_o` and `baud_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch strobe; accepted only when idle |
| in_freq_i | input | FREQ_W | Input clock frequency in Hz |
| ratio_i | input | RATIO_W | Multiply or divide ratio |
| div_sel_i | input | 1 | 1 = divide mode, 0 = multiply mode |
| op_min_i | input | FREQ_W+RATIO_W | Lowest allowed operating frequency |
| op_max_i | input | FREQ_W+RATIO_W | Highest allowed operating frequency |
| per_clk_i | input | PCLK_W | Peripheral clock frequency in Hz |
| baud_i | input | BR_W | Requested bit rate B |
| cks_i | input | 2 | Clock-select code n (0 to 3) |
| brdiv_i | input | NDIV_W | Divisor value N |
| done_o | output | 1 | One-cycle completion pulse |
| freq_err_o | output | 1 | Operating-frequency error flag |
| baud_err_o | output | 1 | Bit-rate error flag |

## Verification
The assertions assume a few things about the inputs:
- `start_i` is a clean synchronous strobe.
- All parameters meet their port widths. In particular, `per_clk_i` and the denominator both fit within the 5-bit headroom of the comparison width.
- The window is given with `op_min_i ≤ op_max_i`.

The divider's exactness assertion applies only when the latched divisor is nonzero, because a zero divisor is instead covered by the error flag. The stimulus stays inside these limits. It uses bit rates up to 115200, divisors up to 255 and peripheral clocks within a few percent of the computed denominator. It sets the window once per sweep so that the minimum lies below the maximum. Exact bounds and the exact 4 % point are placed deliberately on both sides of each threshold.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALC,
        ST_JUDGE,
        ST_REPORT
    } bpc_state_e;

    // Left shift that realises 64 * 2^(2n-1) for clock-select code n.
    function automatic logic [3:0] cks_to_shift(input logic [1:0] cks);
        return 4'd5 + {1'b0, cks, 1'b0};
    endfunction

endpackage

// File: rtl/bpc_seq_mul.sv
module bpc_seq_mul #(
    parameter int AW = 32,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [AW-1:0]    a,
    input  logic [BW-1:0]    b,
    output logic             done,
    output logic [AW+BW-1:0] prod
);
    localparam int PW = AW + BW;
    localparam int CW = $clog2(BW + 1);

    logic [PW-1:0] acc_r;
    logic [PW-1:0] mcand_r;
    logic [BW-1:0] mplier_r;
    logic [CW-1:0] cnt_r;
    logic          active_r;
    logic          done_r;
    logic [AW-1:0] a_q;
    logic [BW-1:0] b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_r    <= '0;
            mcand_r  <= '0;
            mplier_r <= '0;
            cnt_r    <= '0;
            active_r <= 1'b0;
            done_r   <= 1'b0;
            a_q      <= '0;
            b_q      <= '0;
        end else if (go) begin
            acc_r    <= '0;
            mcand_r  <= PW'(a);
            mplier_r <= b;
            cnt_r    <= CW'(BW);
            active_r <= 1'b1;
            done_r   <= 1'b0;
            a_q      <= a;
            b_q      <= b;
        end else if (active_r) begin
            if (mplier_r[0]) begin
                acc_r <= acc_r + mcand_r;
            end
            mcand_r  <= mcand_r << 1;
            mplier_r <= mplier_r >> 1;
            cnt_r    <= cnt_r - 1'b1;
            if (cnt_r == CW'(1)) begin
                active_r <= 1'b0;
                done_r   <= 1'b1;
            end
        end else begin
            done_r <= 1'b0;
        end
    end

    assign done = done_r;
    assign prod = acc_r;

    // R1 / R4: the shift-add product equals the true product of the latched operands.
    p_mul_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_r |-> (acc_r == PW'(a_q) * PW'(b_q)));

    p_mul_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_r |=> !done_r);

endmodule

// File: rtl/bpc_seq_div.sv
module bpc_seq_div #(
    parameter int NW = 32,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          done,
    output logic [NW-1:0] quo
);
    localparam int CW = $clog2(NW + 1);
    localparam int XW = NW + DW;

    logic [NW-1:0] quo_r;
    logic [DW-1:0] rem_r;
    logic [DW-1:0] den_q;
    logic [NW-1:0] num_q;
    logic [CW-1:0] cnt_r;
    logic          active_r;
    logic          done_r;
    logic [DW:0]   trial;
    logic          fits;

    always_comb begin
        trial = {rem_r, quo_r[NW-1]};
        fits  = (trial >= {1'b0, den_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_r    <= '0;
            rem_r    <= '0;
            den_q    <= '0;
            num_q    <= '0;
            cnt_r    <= '0;
            active_r <= 1'b0;
            done_r   <= 1'b0;
        end else if (go) begin
            quo_r    <= num;
            rem_r    <= '0;
            den_q    <= den;
            num_q    <= num;
            cnt_r    <= CW'(NW);
            active_r <= 1'b1;
            done_r   <= 1'b0;
        end else if (active_r) begin
            quo_r <= {quo_r[NW-2:0], fits};
            rem_r <= fits ? DW'(trial - {1'b0, den_q}) : DW'(trial);
            cnt_r <= cnt_r - 1'b1;
            if (cnt_r == CW'(1)) begin
                active_r <= 1'b0;
                done_r   <= 1'b1;
            end
        end else begin
            done_r <= 1'b0;
        end
    end

    assign done = done_r;
    assign quo  = quo_r;

    // R2: truncating division, quotient * divisor + remainder rebuilds the dividend.
    p_div_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_r && den_q != '0) |->
            ((XW'(quo_r) * XW'(den_q) + XW'(rem_r) == XW'(num_q)) && (rem_r < den_q)));

endmodule

// File: rtl/bootparam_checker.sv
module bootparam_checker #(
    parameter int FREQ_W  = 32,
    parameter int RATIO_W = 8,
    parameter int PCLK_W  = 40,
    parameter int BR_W    = 20,
    parameter int NDIV_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [FREQ_W-1:0]         in_freq_i,
    input  logic [RATIO_W-1:0]        ratio_i,
    input  logic                      div_sel_i,
    input  logic [FREQ_W+RATIO_W-1:0] op_min_i,
    input  logic [FREQ_W+RATIO_W-1:0] op_max_i,
    input  logic [PCLK_W-1:0]         per_clk_i,
    input  logic [BR_W-1:0]           baud_i,
    input  logic [1:0]                cks_i,
    input  logic [NDIV_W-1:0]         brdiv_i,
    output logic                      done_o,
    output logic                      freq_err_o,
    output logic                      baud_err_o
);
    import bpc_pkg::*;

    localparam int OPF_W  = FREQ_W + RATIO_W;
    localparam int NB_W   = NDIV_W + 1 + BR_W;
    localparam int DEN_W  = NB_W + 11;
    localparam int BASE_W = (PCLK_W > DEN_W) ? PCLK_W : DEN_W;
    localparam int WIDE_W = BASE_W + 5;

    bpc_state_e state_q, state_d;

    logic             accept;
    logic             fmul_done, fdiv_done, bmul_done;
    logic [OPF_W-1:0] fprod;
    logic [FREQ_W-1:0] fquo;
    logic [NB_W-1:0]  bprod;
    logic [NDIV_W:0]  brdiv_p1;

    logic             f_seen_q, b_seen_q, f_fin, b_fin;
    logic [OPF_W-1:0] opf_q, min_q, max_q;
    logic [NB_W-1:0]  nb_q;
    logic [PCLK_W-1:0] pclk_q;
    logic [3:0]       shift_q;
    logic             div_q, ratio_zero_q;
    logic             ferr_q, berr_q;

    logic [DEN_W-1:0]  den;
    logic [WIDE_W-1:0] den_w, pclk_w, diff_w, scaled_w;
    logic              freq_bad, baud_bad;

    assign accept   = start_i && (state_q == ST_IDLE);
    assign brdiv_p1 = {1'b0, brdiv_i} + (NDIV_W + 1)'(1);

    bpc_seq_mul #(.AW(FREQ_W), .BW(RATIO_W)) u_fmul (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (accept && !div_sel_i),
        .a    (in_freq_i),
        .b    (ratio_i),
        .done (fmul_done),
        .prod (fprod)
    );

    bpc_seq_div #(.NW(FREQ_W), .DW(RATIO_W)) u_fdiv (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (accept && div_sel_i),
        .num  (in_freq_i),
        .den  (ratio_i),
        .done (fdiv_done),
        .quo  (fquo)
    );

    bpc_seq_mul #(.AW(NDIV_W + 1), .BW(BR_W)) u_bmul (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (accept),
        .a    (brdiv_p1),
        .b    (baud_i),
        .done (bmul_done),
        .prod (bprod)
    );

    assign f_fin = f_seen_q || fmul_done || fdiv_done;
    assign b_fin = b_seen_q || bmul_done;

    // Division-free judgement of both conditions.
    always_comb begin
        den      = DEN_W'(nb_q) << shift_q;
        den_w    = WIDE_W'(den);
        pclk_w   = WIDE_W'(pclk_q);
        diff_w   = (pclk_w >= den_w) ? (pclk_w - den_w) : (den_w - pclk_w);
        scaled_w = (diff_w << 4) + (diff_w << 3) + diff_w;
        baud_bad = (scaled_w >= den_w);
        freq_bad = (div_q && ratio_zero_q) || (opf_q < min_q) || (opf_q > max_q);
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_CALC;
            ST_CALC:   if (f_fin && b_fin) state_d = ST_JUDGE;
            ST_JUDGE:  state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Operand latches and result capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_seen_q     <= 1'b0;
            b_seen_q     <= 1'b0;
            opf_q        <= '0;
            min_q        <= '0;
            max_q        <= '0;
            nb_q         <= '0;
            pclk_q       <= '0;
            shift_q      <= 4'd5;
            div_q        <= 1'b0;
            ratio_zero_q <= 1'b0;
        end else if (accept) begin
            f_seen_q     <= 1'b0;
            b_seen_q     <= 1'b0;
            min_q        <= op_min_i;
            max_q        <= op_max_i;
            pclk_q       <= per_clk_i;
            shift_q      <= cks_to_shift(cks_i);
            div_q        <= div_sel_i;
            ratio_zero_q <= (ratio_i == '0);
        end else begin
            if (fmul_done) begin
                f_seen_q <= 1'b1;
                opf_q    <= fprod;
            end
            if (fdiv_done) begin
                f_seen_q <= 1'b1;
                opf_q    <= OPF_W'(fquo);
            end
            if (bmul_done) begin
                b_seen_q <= 1'b1;
                nb_q     <= bprod;
            end
        end
    end

    // Flag registers: cleared on launch, set in ST_JUDGE.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ferr_q <= 1'b0;
            berr_q <= 1'b0;
        end else if (accept) begin
            ferr_q <= 1'b0;
            berr_q <= 1'b0;
        end else if (state_q == ST_JUDGE) begin
            ferr_q <= freq_bad;
            berr_q <= baud_bad;
        end
    end

    // Outputs.
    always_comb begin
        done_o     = (state_q == ST_REPORT);
        freq_err_o = ferr_q;
        baud_err_o = berr_q;
    end

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_JUDGE && !accept) |=> $stable({freq_err_o, baud_err_o}));

    p_busy_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CALC) |=> ($stable(pclk_q) && $stable(shift_q) && $stable(min_q) && $stable(max_q)));

    p_divzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JUDGE && div_q && ratio_zero_q) |=> (freq_err_o && done_o));

    p_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state_q == ST_CALC && !done_o));

endmodule

// File: tb/sim_bootparam_checker.sv
module sim_bootparam_checker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] in_freq = '0;
    logic [7:0]  ratio = '0;
    logic        div_sel = 1'b0;
    logic [39:0] op_min = '0;
    logic [39:0] op_max = '0;
    logic [39:0] per_clk = '0;
    logic [19:0] baud = '0;
    logic [1:0]  cks = '0;
    logic [7:0]  brdiv = '0;
    logic        done, ferr, berr;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bootparam_checker u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .in_freq_i (in_freq),
        .ratio_i   (ratio),
        .div_sel_i (div_sel),
        .op_min_i  (op_min),
        .op_max_i  (op_max),
        .per_clk_i (per_clk),
        .baud_i    (baud),
        .cks_i     (cks),
        .brdiv_i   (brdiv),
        .done_o    (done),
        .freq_err_o(ferr),
        .baud_err_o(berr)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_ferr(longint unsigned f, longint unsigned r, bit dv,
                                    longint unsigned lo, longint unsigned hi);
        longint unsigned op;
        if (dv && r == 0) return 1'b1;
        op = dv ? (f / r) : (f * r);
        return (op < lo) || (op > hi);
    endfunction

    function automatic bit exp_berr(longint unsigned pc, longint unsigned b, int n,
                                    longint unsigned nd);
        longint unsigned d, df;
        d  = ((nd + 1) * b) << (5 + 2 * n);
        df = (pc >= d) ? pc - d : d - pc;
        return (25 * df) >= d;
    endfunction

    // One full check; when poke is set, a second start with altered inputs arrives mid-run.
    task automatic run_one(input bit poke, input string tag_f, input string tag_b);
        bit ef, eb;
        int wait_cnt;
        ef = exp_ferr(in_freq, ratio, div_sel, op_min, op_max);
        eb = exp_berr(per_clk, baud, cks, brdiv);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_cnt = 0;
        while (!done && wait_cnt < 200) begin
            if (poke && wait_cnt == 3) begin
                start   = 1'b1;
                div_sel = ~div_sel;
                ratio   = 8'd0;
                per_clk = '0;
                op_min  = '1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            wait_cnt++;
        end
        start = 1'b0;
        chk(done == 1'b1, "R6 done reached", longint'(done), 1);
        chk(ferr == ef, tag_f, longint'(ferr), longint'(ef));
        chk(berr == eb, tag_b, longint'(berr), longint'(eb));
        @(negedge clk);
        chk(done == 1'b0, "R6 done one cycle", longint'(done), 0);
        repeat (2) @(negedge clk);
        chk(ferr == ef && berr == eb, "R6 flags held", longint'({ferr, berr}), longint'({ef, eb}));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        longint unsigned fins [4] = '{64'd20000000, 64'd10000000, 64'd80000001, 64'd12345678};
        longint unsigned bauds [3] = '{64'd9600, 64'd115200, 64'd0};
        longint unsigned ndivs [4] = '{64'd0, 64'd1, 64'd7, 64'd255};
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(done == 0 && ferr == 0 && berr == 0, "R8 reset outputs",
            longint'({done, ferr, berr}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3: frequency sweep with a known-good bit-rate setting
        op_min  = 40'd20000000;
        op_max  = 40'd80000000;
        baud    = 20'd9600;
        brdiv   = 8'd0;
        cks     = 2'd0;
        per_clk = 40'd307200;
        for (int fi = 0; fi < 4; fi++) begin
            for (int r = 0; r < 16; r++) begin
                for (int m = 0; m < 2; m++) begin
                    in_freq = 32'(fins[fi]);
                    ratio   = 8'(r);
                    div_sel = 1'(m);
                    if (m == 0) run_one(1'b0, "R1 multiply window", "R5 baud fixed");
                    else if (r == 0) run_one(1'b0, "R3 zero ratio", "R5 baud fixed");
                    else run_one(1'b0, "R2 divide window", "R5 baud fixed");
                end
            end
        end

        // R4 R5: bit-rate sweep around the 4 % threshold, frequency kept valid
        in_freq = 32'd20000000;
        ratio   = 8'd2;
        div_sel = 1'b0;
        for (int n = 0; n < 4; n++) begin
            for (int ni = 0; ni < 4; ni++) begin
                for (int bi = 0; bi < 3; bi++) begin
                    for (int v = 0; v < 5; v++) begin
                        longint unsigned d, q;
                        d = ((ndivs[ni] + 1) * bauds[bi]) << (5 + 2 * n);
                        q = d / 25;
                        cks   = 2'(n);
                        brdiv = 8'(ndivs[ni]);
                        baud  = 20'(bauds[bi]);
                        case (v)
                            0: per_clk = 40'(d);
                            1: per_clk = 40'(d + q);
                            2: per_clk = 40'(d + q - ((q > 0) ? 1 : 0));
                            3: per_clk = 40'(d - q);
                            default: per_clk = 40'(d - q + 1);
                        endcase
                        run_one(1'b0, "R1 freq fixed", "R4 R5 baud threshold");
                    end
                end
            end
        end

        // R5: exact 4 % boundary, n=0 N=0 B=9600, den=307200
        cks = 2'd0; brdiv = 8'd0; baud = 20'd9600;
        per_clk = 40'd319488;
        run_one(1'b0, "R1 freq fixed", "R5 exactly 4 percent flagged");
        per_clk = 40'd319487;
        run_one(1'b0, "R1 freq fixed", "R5 below 4 percent passes");

        // R7: start during a run is ignored
        in_freq = 32'd40000000; ratio = 8'd1; div_sel = 1'b0;
        op_min = 40'd20000000; op_max = 40'd80000000;
        per_clk = 40'd307200;
        run_one(1'b1, "R7 busy start ignored freq", "R7 busy start ignored baud");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule